// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After reset, this block reads a small three-wire serial EEPROM and fills a set of device configuration registers from it. The host finds these values already in place when it first probes the device. The EEPROM holds 2K bits and is addressed as 128 sixteen-bit words. A strap sampled once at startup selects how the part is organised. In word organisation, each 16-bit word takes one read with a 7-bit word index. In byte organisation, each word takes two 8-bit reads with an 8-bit byte address. The strap value is also driven onto the EEPROM's organisation pin.

A load runs only when two conditions hold. First, the handshake input of port 0 must be de-asserted when it is sampled at startup. Second, word 0 must equal a fixed check code. When the load goes ahead, the remaining words are scattered into fields of 32-bit registers through a fixed map. Word 6 is never fetched. When the load is refused, every register keeps its default value. A sticky flag reports which of the two outcomes occurred.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Both straps are sampled in the first clock after reset is released. `mw_org` equals the sampled organisation strap (1 = word organisation) until the next reset. Later changes to `org_strap` have no effect on `mw_org` or on the load.
- R2: If `port0_rts` is high when it is sampled, `load_skipped` rises, chip select is never asserted, and every register keeps its default. If `port0_rts` rises after the sample, it has no effect.
- R3: Each read is framed by chip select. It sends a start bit of 1, then the opcode 10b, then the address, most significant bit first. `mw_mosi` changes only while `mw_sk` is low.
- R4: After the address, the block samples `mw_miso` on rising `mw_sk` edges. The first sample is a dummy bit and is discarded. In word organisation, 16 data bits then follow, most significant bit first.
- R5: In byte organisation, word w takes two reads. The low byte comes from byte address 2w and the high byte from 2w+1, each read returning 8 data bits after the dummy bit.
- R6: Word 0 is compared with `SIG_CODE`. On a mismatch, no further read is issued, `load_skipped` rises and every register keeps its default.
- R7: Words 1 and 2 load `reg_ident[15:0]` and `reg_ident[31:16]`. Words 3 and 4 load `reg_subsys[15:0]` and `reg_subsys[31:16]`.
- R8: Word 5 is split as follows:
  - bits 10:0 go to `reg_pwr[31:21]`;
  - bit 11 goes to `reg_misc[3]`;
  - bits 13:12 go to `reg_link[14:13]`;
  - bits 15:14 are ignored, and all other bits of these registers keep their defaults.
- R9: Words 7 and 8 load the low and high halves of `reg_timer`. Word 9 loads `reg_lat[15:0]`, and `reg_lat[31:16]` keeps its default. The reads are issued in the order 0 to 5, then 7 to 9, and word 6 is never read.
- R10: While reset is held, both flags are low and all registers hold their defaults. `load_done` and `load_skipped` are never high together. Once either flag is high, it stays high until the next reset and the registers no longer change.
- R11: `mw_sk` is high only while `mw_cs` is high, and each high phase lasts DIV clocks. Chip select is high for at least 2*DIV clocks before the first rising `mw_sk` edge, and it is low for at least 2*DIV clocks between reads.
- R12: Once the load has finished, chip select is not asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| org_strap | input | 1 | Organisation strap, 1 = word access |
| port0_rts | input | 1 | Port 0 handshake; high at startup blocks the load |
| mw_cs | output | 1 | EEPROM chip select |
| mw_sk | output | 1 | EEPROM serial clock |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| mw_miso | input | 1 | Serial data from the EEPROM |
| mw_org | output | 1 | Organisation select driven to the EEPROM |
| load_done | output | 1 | Sticky: load completed |
| load_skipped | output | 1 | Sticky: load refused |
| reg_ident | output | 32 | Identity register (vendor low, device high) |
| reg_subsys | output | 32 | Subsystem identity register |
| reg_pwr | output | 32 | Power capability register |
| reg_misc | output | 32 | Miscellaneous control register |
| reg_link | output | 32 | Link capability register |
| reg_timer | output | 32 | Replay and acknowledge timer register |
| reg_lat | output | 32 | Latency register |

## Verification
The bench models the EEPROM and runs loads in both organisations with distinct data. It checks the order of the read addresses, so an engine that fetches word 6 is caught. So is a byte-mode engine that swaps the two halves or reuses the word index. The scatter word is loaded with all ones against non-zero defaults. A wrong bit position, or a write that spills into neighbouring bits, shows up as a corrupted default. The bench also covers a bad signature, a blocked startup and straps that toggle after sampling. A design that keeps reading, writes before checking the signature, or resamples a strap ends with the wrong read count or wrong register values. Bus timing is measured for every read, so a missing chip select setup, hold or gap, or an uneven clock phase, is reported.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_SIG   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ID_LO = 4'd1;
  localparam logic [IDX_W-1:0] IDX_ID_HI = 4'd2;
  localparam logic [IDX_W-1:0] IDX_SS_LO = 4'd3;
  localparam logic [IDX_W-1:0] IDX_SS_HI = 4'd4;
  localparam logic [IDX_W-1:0] IDX_PWR   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_GAP   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_TM_LO = 4'd7;
  localparam logic [IDX_W-1:0] IDX_TM_HI = 4'd8;
  localparam logic [IDX_W-1:0] IDX_LAT   = 4'd9;
  localparam logic [IDX_W-1:0] IDX_LAST  = 4'd9;

  localparam logic [1:0] RD_OPCODE = 2'b10;

  typedef enum logic [2:0] {LD_BOOT, LD_ISSUE, LD_WAIT, LD_FIN, LD_DONE, LD_SKIP} ld_state_t;
  typedef enum logic [2:0] {MW_IDLE, MW_SETUP, MW_SHIFT, MW_HOLD, MW_GAP} mw_state_t;
endpackage

// File: rtl/eeld_mw_reader.sv
module eeld_mw_reader
  import eeld_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int WADDR_W = 7,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_mode,
  input  logic               start,
  input  logic [WADDR_W:0]   addr,
  output logic               rd_done,
  output logic [WORD_W-1:0]  rd_data,
  output logic               cs,
  output logic               sk,
  output logic               mosi,
  input  logic               miso
);
  localparam int BADDR_W = WADDR_W + 1;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int CMD_W   = 3 + BADDR_W;
  localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BIT_W   = $clog2(CMD_W + WORD_W + 1);

  mw_state_t          st;
  logic [DIV_W-1:0]   div_cnt;
  logic               tick;
  logic               ph;
  logic [BIT_W-1:0]   bit_cnt;
  logic [BIT_W-1:0]   n_cmd;
  logic [BIT_W-1:0]   n_tot;
  logic [CMD_W-1:0]   cmd_sr;
  logic [WORD_W-1:0]  rx_sr;

  assign tick  = (div_cnt == DIV_W'(DIV - 1));
  assign n_cmd = word_mode ? BIT_W'(CMD_W - 1) : BIT_W'(CMD_W);
  assign n_tot = word_mode ? BIT_W'(CMD_W + WORD_W) : BIT_W'(CMD_W + 1 + BYTE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= MW_IDLE;
      div_cnt <= '0;
      ph      <= 1'b0;
      bit_cnt <= '0;
      cmd_sr  <= '0;
      rx_sr   <= '0;
      cs      <= 1'b0;
      sk      <= 1'b0;
      mosi    <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      if (st == MW_IDLE || tick) div_cnt <= '0;
      else div_cnt <= div_cnt + 1'b1;
      case (st)
        MW_IDLE: if (start) begin
          cs      <= 1'b1;
          sk      <= 1'b0;
          ph      <= 1'b0;
          bit_cnt <= '0;
          rx_sr   <= '0;
          cmd_sr  <= word_mode ? {1'b1, RD_OPCODE, addr[WADDR_W-1:0], 1'b0}
                               : {1'b1, RD_OPCODE, addr};
          mosi    <= 1'b1;
          st      <= MW_SETUP;
        end
        MW_SETUP: if (tick) begin
          ph <= ~ph;
          if (ph) st <= MW_SHIFT;
        end
        MW_SHIFT: if (tick) begin
          if (!sk) begin
            sk <= 1'b1;
            if (bit_cnt >= n_cmd) rx_sr <= {rx_sr[WORD_W-2:0], miso};
          end else begin
            sk <= 1'b0;
            if (bit_cnt == n_tot - 1'b1) begin
              mosi <= 1'b0;
              st   <= MW_HOLD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              mosi    <= cmd_sr[CMD_W-2];
              cmd_sr  <= {cmd_sr[CMD_W-2:0], 1'b0};
            end
          end
        end
        MW_HOLD: if (tick) begin
          ph <= ~ph;
          if (ph) begin
            cs <= 1'b0;
            st <= MW_GAP;
          end
        end
        MW_GAP: if (tick) begin
          ph <= ~ph;
          if (ph) begin
            st      <= MW_IDLE;
            rd_done <= 1'b1;
            rd_data <= word_mode ? rx_sr : {{BYTE_W{1'b0}}, rx_sr[BYTE_W-1:0]};
          end
        end
        default: st <= MW_IDLE;
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) sk |-> cs); // R11
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(mosi)); // R3
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst) rd_done |-> !cs); // R11
endmodule

// File: rtl/eeld_cfg_regs.sv
module eeld_cfg_regs
  import eeld_pkg::*;
#(
  parameter int          WORD_W     = 16,
  parameter logic [31:0] DEF_IDENT  = 32'h7954_A868,
  parameter logic [31:0] DEF_SUBSYS = 32'h7954_12D8,
  parameter logic [31:0] DEF_PWR    = 32'h0000_0000,
  parameter logic [31:0] DEF_MISC   = 32'h0000_0000,
  parameter logic [31:0] DEF_LINK   = 32'h0000_0000,
  parameter logic [31:0] DEF_TIMER  = 32'h0000_0000,
  parameter logic [31:0] DEF_LAT    = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [31:0]       reg_ident,
  output logic [31:0]       reg_subsys,
  output logic [31:0]       reg_pwr,
  output logic [31:0]       reg_misc,
  output logic [31:0]       reg_link,
  output logic [31:0]       reg_timer,
  output logic [31:0]       reg_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ident  <= DEF_IDENT;
      reg_subsys <= DEF_SUBSYS;
      reg_pwr    <= DEF_PWR;
      reg_misc   <= DEF_MISC;
      reg_link   <= DEF_LINK;
      reg_timer  <= DEF_TIMER;
      reg_lat    <= DEF_LAT;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_ID_LO: reg_ident[15:0]   <= wr_data;
        IDX_ID_HI: reg_ident[31:16]  <= wr_data;
        IDX_SS_LO: reg_subsys[15:0]  <= wr_data;
        IDX_SS_HI: reg_subsys[31:16] <= wr_data;
        IDX_PWR: begin
          reg_pwr[31:21]  <= wr_data[10:0];
          reg_misc[3]     <= wr_data[11];
          reg_link[14:13] <= wr_data[13:12];
        end
        IDX_TM_LO: reg_timer[15:0]   <= wr_data;
        IDX_TM_HI: reg_timer[31:16]  <= wr_data;
        IDX_LAT:   reg_lat[15:0]     <= wr_data;
        default: ;
      endcase
    end
  end

  AST_PWR_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> reg_pwr[20:0] == $past(reg_pwr[20:0])); // R8
  AST_NO_GAP_WORD: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_idx != IDX_GAP); // R9
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eeld_pkg::*;
#(
  parameter int          DIV        = 4,
  parameter logic [15:0] SIG_CODE   = 16'hC35A,
  parameter logic [31:0] DEF_IDENT  = 32'h7954_A868,
  parameter logic [31:0] DEF_SUBSYS = 32'h7954_12D8,
  parameter logic [31:0] DEF_PWR    = 32'h0000_0000,
  parameter logic [31:0] DEF_MISC   = 32'h0000_0000,
  parameter logic [31:0] DEF_LINK   = 32'h0000_0000,
  parameter logic [31:0] DEF_TIMER  = 32'h0000_0000,
  parameter logic [31:0] DEF_LAT    = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        org_strap,
  input  logic        port0_rts,
  output logic        mw_cs,
  output logic        mw_sk,
  output logic        mw_mosi,
  input  logic        mw_miso,
  output logic        mw_org,
  output logic        load_done,
  output logic        load_skipped,
  output logic [31:0] reg_ident,
  output logic [31:0] reg_subsys,
  output logic [31:0] reg_pwr,
  output logic [31:0] reg_misc,
  output logic [31:0] reg_link,
  output logic [31:0] reg_timer,
  output logic [31:0] reg_lat
);
  localparam int WADDR_W = 7;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = WORD_W / 2;

  ld_state_t          st;
  logic               org_q;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   idx_next;
  logic               hi_half;
  logic [BYTE_W-1:0]  lo_byte;
  logic               rd_start;
  logic [WADDR_W:0]   rd_addr;
  logic               rd_done;
  logic [WORD_W-1:0]  rd_data;
  logic [WORD_W-1:0]  word_now;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [WORD_W-1:0]  wr_data;

  assign mw_org   = org_q;
  assign word_now = org_q ? rd_data : {rd_data[BYTE_W-1:0], lo_byte};
  assign idx_next = (idx + 1'b1 == IDX_GAP) ? idx + 4'd2 : idx + 1'b1;
  assign rd_addr  = org_q ? (WADDR_W+1)'(idx) : (WADDR_W+1)'({idx, hi_half});

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= LD_BOOT;
      org_q        <= 1'b1;
      idx          <= IDX_SIG;
      hi_half      <= 1'b0;
      lo_byte      <= '0;
      rd_start     <= 1'b0;
      wr_en        <= 1'b0;
      wr_idx       <= '0;
      wr_data      <= '0;
      load_done    <= 1'b0;
      load_skipped <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      wr_en    <= 1'b0;
      case (st)
        LD_BOOT: begin
          org_q <= org_strap;
          st    <= port0_rts ? LD_SKIP : LD_ISSUE;
        end
        LD_ISSUE: begin
          rd_start <= 1'b1;
          st       <= LD_WAIT;
        end
        LD_WAIT: if (rd_done) begin
          if (!org_q && !hi_half) begin
            lo_byte <= rd_data[BYTE_W-1:0];
            hi_half <= 1'b1;
            st      <= LD_ISSUE;
          end else begin
            hi_half <= 1'b0;
            if (idx == IDX_SIG) begin
              if (word_now != SIG_CODE) st <= LD_SKIP;
              else begin
                idx <= idx_next;
                st  <= LD_ISSUE;
              end
            end else begin
              wr_en   <= 1'b1;
              wr_idx  <= idx;
              wr_data <= word_now;
              if (idx == IDX_LAST) st <= LD_FIN;
              else begin
                idx <= idx_next;
                st  <= LD_ISSUE;
              end
            end
          end
        end
        LD_FIN: begin
          load_done <= 1'b1;
          st        <= LD_DONE;
        end
        LD_SKIP: load_skipped <= 1'b1;
        default: ;
      endcase
    end
  end

  eeld_mw_reader #(.DIV(DIV), .WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_reader (
    .clk(clk), .rst(rst), .word_mode(org_q), .start(rd_start), .addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data),
    .cs(mw_cs), .sk(mw_sk), .mosi(mw_mosi), .miso(mw_miso)
  );

  eeld_cfg_regs #(
    .WORD_W(WORD_W), .DEF_IDENT(DEF_IDENT), .DEF_SUBSYS(DEF_SUBSYS), .DEF_PWR(DEF_PWR),
    .DEF_MISC(DEF_MISC), .DEF_LINK(DEF_LINK), .DEF_TIMER(DEF_TIMER), .DEF_LAT(DEF_LAT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .reg_ident(reg_ident), .reg_subsys(reg_subsys), .reg_pwr(reg_pwr), .reg_misc(reg_misc),
    .reg_link(reg_link), .reg_timer(reg_timer), .reg_lat(reg_lat)
  );

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_skipped)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done); // R10
  AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    load_skipped |=> load_skipped); // R6
  AST_ORG_HELD: assert property (@(posedge clk) disable iff (rst)
    (st != LD_BOOT) |=> $stable(mw_org)); // R1
  AST_SKIP_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    load_skipped |-> !mw_cs); // R2
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !mw_cs); // R12
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (load_done || load_skipped) |=> ($stable(reg_ident) && $stable(reg_pwr) && $stable(reg_timer))); // R10
endmodule

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIV        = 3;
  localparam logic [15:0] SIG        = 16'hC35A;
  localparam logic [31:0] D_IDENT    = 32'h7954_A868;
  localparam logic [31:0] D_SUBSYS   = 32'h7954_12D8;
  localparam logic [31:0] D_PWR      = 32'h0015_5A5A;
  localparam logic [31:0] D_MISC     = 32'hF0F0_00F5;
  localparam logic [31:0] D_LINK     = 32'h0000_9F9F;
  localparam logic [31:0] D_TIMER    = 32'h1234_5678;
  localparam logic [31:0] D_LAT      = 32'hABCD_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic org_strap = 1'b1;
  logic port0_rts = 1'b0;
  logic mw_cs, mw_sk, mw_mosi, mw_org, load_done, load_skipped;
  logic mw_miso;
  logic [31:0] reg_ident, reg_subsys, reg_pwr, reg_misc, reg_link, reg_timer, reg_lat;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_cfg_loader #(
    .DIV(DIV), .SIG_CODE(SIG), .DEF_IDENT(D_IDENT), .DEF_SUBSYS(D_SUBSYS), .DEF_PWR(D_PWR),
    .DEF_MISC(D_MISC), .DEF_LINK(D_LINK), .DEF_TIMER(D_TIMER), .DEF_LAT(D_LAT)
  ) dut (
    .clk(clk), .rst(rst), .org_strap(org_strap), .port0_rts(port0_rts),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_mosi(mw_mosi), .mw_miso(mw_miso), .mw_org(mw_org),
    .load_done(load_done), .load_skipped(load_skipped),
    .reg_ident(reg_ident), .reg_subsys(reg_subsys), .reg_pwr(reg_pwr), .reg_misc(reg_misc),
    .reg_link(reg_link), .reg_timer(reg_timer), .reg_lat(reg_lat)
  );

  // EEPROM model: low byte of word w at byte 2w, high byte at 2w+1
  logic [7:0]  mem [0:255];
  logic        m_word = 1'b1;
  logic        started = 1'b0;
  int          mcnt = 0;
  logic [1:0]  mop = 2'b00;
  logic [7:0]  maddr = 8'h00;
  logic [15:0] mout = 16'h0000;
  logic        mdo = 1'b0;
  int          n_reads = 0;
  int          op_err = 0;
  int          addr_log [0:31];

  assign mw_miso = mdo;

  always @(posedge mw_sk or negedge mw_cs) begin
    if (!mw_cs) begin
      started = 1'b0;
      mcnt = 0;
      mdo = 1'b0;
    end else if (!started) begin
      if (mw_mosi) begin
        started = 1'b1;
        mcnt = 1;
        mop = 2'b00;
        maddr = 8'h00;
      end
    end else if (mcnt < (m_word ? 10 : 11)) begin
      if (mcnt < 3) mop = {mop[0], mw_mosi};
      else maddr = {maddr[6:0], mw_mosi};
      mcnt++;
      if (mcnt == (m_word ? 10 : 11)) begin
        if (mop != 2'b10) op_err++;
        if (n_reads < 32) addr_log[n_reads] = int'(maddr);
        n_reads++;
        if (m_word) mout = {mem[2*int'(maddr)+1], mem[2*int'(maddr)]};
        else mout = {mem[int'(maddr)], 8'h00};
        mdo = 1'b0;
      end
    end else begin
      mdo = mout[15];
      mout = {mout[14:0], 1'b0};
    end
  end

  // bus timing monitor
  logic cs_prev = 1'b0, sk_prev = 1'b0, armed = 1'b0;
  int cs_rises = 0, since_cs = 0, low_cnt = 0, sk_hi = 0;
  int min_setup = 1000000, min_gap = 1000000, sk_bad = 0, sk_wo_cs = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mw_sk && !mw_cs) sk_wo_cs++;
      if (mw_cs && !cs_prev) begin
        if (cs_rises > 0 && low_cnt < min_gap) min_gap = low_cnt;
        cs_rises++;
        since_cs = 0;
        armed = 1'b1;
      end
      if (mw_cs) since_cs++;
      if (mw_sk && !sk_prev && armed) begin
        if (since_cs < min_setup) min_setup = since_cs;
        armed = 1'b0;
      end
      if (mw_sk) sk_hi++;
      if (!mw_sk && sk_prev) begin
        if (sk_hi != DIV) sk_bad++;
        sk_hi = 0;
      end
      if (!mw_cs) low_cnt++;
      else low_cnt = 0;
      cs_prev = mw_cs;
      sk_prev = mw_sk;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int w);
    return {mem[2*w+1], mem[2*w]};
  endfunction

  task automatic fill(input int seed, input logic [15:0] w5);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + seed);
    mem[0] = SIG[7:0];
    mem[1] = SIG[15:8];
    mem[10] = w5[7:0];
    mem[11] = w5[15:8];
  endtask

  task automatic do_reset(input logic org, input logic rts);
    @(negedge clk);
    rst = 1'b1;
    org_strap = org;
    port0_rts = rts;
    m_word = org;
    repeat (4) @(negedge clk);
    n_reads = 0; op_err = 0; cs_rises = 0; low_cnt = 0; sk_hi = 0; armed = 1'b0;
    min_setup = 1000000; min_gap = 1000000; sk_bad = 0; sk_wo_cs = 0;
    cs_prev = 1'b0; sk_prev = 1'b0;
    rst = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!load_done && !load_skipped && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 40000) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: load never finished actual=%0d expected<40000", n);
    end
  endtask

  task automatic check_defaults(input string req);
    check({req, " ident"}, reg_ident, D_IDENT);
    check({req, " subsys"}, reg_subsys, D_SUBSYS);
    check({req, " pwr"}, reg_pwr, D_PWR);
    check({req, " misc"}, reg_misc, D_MISC);
    check({req, " link"}, reg_link, D_LINK);
    check({req, " timer"}, reg_timer, D_TIMER);
    check({req, " lat"}, reg_lat, D_LAT);
  endtask

  task automatic check_loaded();
    logic [15:0] w5;
    w5 = wd(5);
    check("R4 R7 ident", reg_ident, {wd(2), wd(1)});
    check("R7 subsys", reg_subsys, {wd(4), wd(3)});
    check("R8 pwr", reg_pwr, {w5[10:0], D_PWR[20:0]});
    check("R8 misc", reg_misc, {D_MISC[31:4], w5[11], D_MISC[2:0]});
    check("R8 link", reg_link, {D_LINK[31:15], w5[13:12], D_LINK[12:0]});
    check("R9 timer", reg_timer, {wd(8), wd(7)});
    check("R9 lat", reg_lat, {D_LAT[31:16], wd(9)});
  endtask

  task automatic check_timing();
    check("R11 sk without cs", 32'(sk_wo_cs), 32'd0);
    check("R11 sk high width", 32'(sk_bad), 32'd0);
    check("R11 cs setup ok", 32'(min_setup >= 2*DIV), 32'd1);
    check("R11 cs gap ok", 32'(min_gap >= 2*DIV), 32'd1);
    check("R3 opcode errors", 32'(op_err), 32'd0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset done", 32'(load_done), 32'd0);
    check("R10 reset skipped", 32'(load_skipped), 32'd0);
    check("R10 reset cs", 32'(mw_cs), 32'd0);
    check_defaults("R10 reset");
  endtask

  task automatic t_word_load();
    int exp_idx [0:8] = '{0, 1, 2, 3, 4, 5, 7, 8, 9};
    fill(5, 16'hFFFF);
    do_reset(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    org_strap = 1'b0;
    port0_rts = 1'b1;
    wait_end();
    check("R10 word done", 32'(load_done), 32'd1);
    check("R10 word skipped", 32'(load_skipped), 32'd0);
    check("R1 org held", 32'(mw_org), 32'd1);
    check("R2 late rts ignored reads", 32'(n_reads), 32'd9);
    check_loaded();
    for (int k = 0; k < 9; k++) check("R3 R9 word addr", 32'(addr_log[k]), 32'(exp_idx[k]));
    check_timing();
    repeat (500) @(negedge clk);
    check("R12 no cs after done", 32'(cs_rises), 32'd9);
    check("R10 done sticky", 32'(load_done), 32'd1);
    check("R10 regs frozen", reg_timer, {wd(8), wd(7)});
  endtask

  task automatic t_byte_load();
    int exp_idx [0:8] = '{0, 1, 2, 3, 4, 5, 7, 8, 9};
    fill(91, 16'h2A95);
    do_reset(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    org_strap = 1'b1;
    wait_end();
    check("R5 byte done", 32'(load_done), 32'd1);
    check("R1 org byte", 32'(mw_org), 32'd0);
    check("R5 byte reads", 32'(n_reads), 32'd18);
    check_loaded();
    for (int k = 0; k < 9; k++) begin
      check("R5 low byte addr", 32'(addr_log[2*k]), 32'(2*exp_idx[k]));
      check("R5 high byte addr", 32'(addr_log[2*k+1]), 32'(2*exp_idx[k]+1));
    end
    check_timing();
  endtask

  task automatic t_bad_sig();
    fill(3, 16'h1234);
    mem[0] = mem[0] ^ 8'h01;
    do_reset(1'b1, 1'b0);
    wait_end();
    repeat (50) @(negedge clk);
    check("R6 skipped", 32'(load_skipped), 32'd1);
    check("R6 not done", 32'(load_done), 32'd0);
    check("R6 single read", 32'(n_reads), 32'd1);
    check_defaults("R6");
  endtask

  task automatic t_blocked();
    fill(7, 16'h0F0F);
    do_reset(1'b1, 1'b1);
    wait_end();
    repeat (200) @(negedge clk);
    check("R2 skipped", 32'(load_skipped), 32'd1);
    check("R2 not done", 32'(load_done), 32'd0);
    check("R2 no cs", 32'(cs_rises), 32'd0);
    check_defaults("R2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run exceeded cycle limit actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_word_load();
    t_byte_load();
    t_bad_sig();
    t_blocked();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule